// File: doc/BRIEF.md
# Countdown Timer with Wrap-Triggered Exception Request

This block holds a down-counting timer register that software can load and read back at any time. Each cycle in which the timebase tick enable is high, the count drops by one. The rate of that tick comes from outside the block, so the same timer serves any tick frequency.

When a decrement carries the count through zero, the block latches a pending timer exception. A decrement through zero is one that takes the count from all zeros to all ones, so the most significant bit goes from 0 to 1. Simply arriving at zero latches nothing.

The exception entry logic sees the request only while the external-enable input is high. The exception is served at vector offset 0x900. While the enable is low, the request stays latched inside the block and is not lost. It is cleared when the processor signals that it has taken the exception, or when software loads a value whose most significant bit is 0.

Top module: `dec_timer`

## Requirements
- R1: After reset the count reads all ones (0xFFFFFFFF at the default width) and no request is pending, so `excReq` is 0.
- R2: A cycle with `wrEn` high loads `wrData` into the count, and `rdData` shows the new value from the next cycle on.
- R3: A cycle with `tickEn` high and `wrEn` low lowers the count by exactly one, wrapping modulo 2^WIDTH. A cycle with neither strobe leaves the count unchanged.
- R4: When `wrEn` and `tickEn` are both high in one cycle, the written value is loaded and no decrement happens in that cycle.
- R5: A pending request is latched only by a decrement in which bit WIDTH-1 of the count goes from 0 to 1, that is, from 0 to all ones. A decrement that ends at 0 latches nothing. A decrement from 0x80000000 to 0x7FFFFFFF latches nothing.
- R6: `excReq` is high exactly when a request is pending and `extEnable` is 1. A pending request stays latched through any number of cycles with `extEnable` at 0.
- R7: `intAck` clears a pending request at the next edge. If a wrap happens in the same cycle as `intAck`, the request stays pending.
- R8: A write whose bit WIDTH-1 is 0 clears a pending request. A write whose bit WIDTH-1 is 1 leaves the pending state as it was.
- R9: A write never latches a request, even when it loads a value with bit WIDTH-1 set over a count whose bit WIDTH-1 was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timebase tick: decrement this cycle |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Value to load on a write |
| rdData | output | 32 | Current count |
| extEnable | input | 1 | External-exception enable bit |
| intAck | input | 1 | Exception taken: clears the pending request |
| excReq | output | 1 | Timer exception request to the exception entry logic |

## Verification
The bench builds the block at its default 32-bit width. At that width the wrap from zero and the 0x80000000 to 0x7FFFFFFF step are the real boundary values, not scaled-down copies. To reach these boundaries often, the random writes favour small counts and counts just above 0x80000000, so that ticks regularly carry the count through zero and across the top bit. Directed sequences then cover the cases that rarely line up by chance:
- a wrap that happens while the request is masked;
- a wrap in the same cycle as an acknowledge;
- a write in the same cycle as a tick;
- writes with the top bit set and with it clear, made while a request is pending.

// File: rtl/dec_timer_pkg.sv
package dec_timer_pkg;
  // Strobes from the control path to the count register
  typedef struct packed {
    logic loadEn;  // load the software value
    logic decEn;   // decrement by one
  } ctrlStrobes_t;
endpackage

// File: rtl/dec_timer_datapath.sv
module dec_timer_datapath
  import dec_timer_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countQ,
  output logic             wrapEvt
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] decVal;
  logic [WIDTH-1:0] countD;

  assign decVal  = countQ - WIDTH'(1);
  // Top bit rising on a decrement means the count passed through zero
  assign wrapEvt = ~countQ[MSB] & decVal[MSB];

  always_comb begin
    countD = countQ;
    if (strb.loadEn)     countD = wrData;
    else if (strb.decEn) countD = decVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= RESET_VAL;
    else       countQ <= countD;
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> countQ == $past(wrData));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decEn && !strb.loadEn) |=> countQ == $past(countQ) - WIDTH'(1));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.decEn && !strb.loadEn) |=> $stable(countQ));
endmodule

// File: rtl/dec_timer_ctrl.sv
module dec_timer_ctrl
  import dec_timer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic         wrMsb,
  input  logic         intAck,
  input  logic         extEnable,
  input  logic         wrapEvt,
  output ctrlStrobes_t strb,
  output logic         excReq
);
  logic pendQ;
  logic setPend;
  logic clrPend;

  // A write outranks a tick in the same cycle
  assign strb.loadEn = wrEn;
  assign strb.decEn  = tickEn & ~wrEn;

  assign setPend = strb.decEn & wrapEvt;
  assign clrPend = intAck | (wrEn & ~wrMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pendQ <= 1'b0;
    else if (setPend) pendQ <= 1'b1;
    else if (clrPend) pendQ <= 1'b0;
  end

  assign excReq = pendQ & extEnable;

  // R4
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !strb.decEn);

  // R6
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !intAck && !(wrEn && !wrMsb)) |=> pendQ);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !(tickEn && !wrEn && wrapEvt)) |=> !pendQ);

  // R8
  low_write_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrMsb) |=> !pendQ);

  // R9
  write_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !pendQ) |=> !pendQ);

  // R5
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrEn && wrapEvt) |=> pendQ);
endmodule

// File: rtl/dec_timer.sv
module dec_timer
  import dec_timer_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic             extEnable,
  input  logic             intAck,
  output logic             excReq
);
  localparam int MSB = WIDTH - 1;

  ctrlStrobes_t strb;
  logic         wrapEvt;

  dec_timer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .wrEn      (wrEn),
    .wrMsb     (wrData[MSB]),
    .intAck    (intAck),
    .extEnable (extEnable),
    .wrapEvt   (wrapEvt),
    .strb      (strb),
    .excReq    (excReq)
  );

  dec_timer_datapath #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .countQ  (rdData),
    .wrapEvt (wrapEvt)
  );

  // R6
  req_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> extEnable);
endmodule

// File: tb/dec_timer_bench.sv
module dec_timer_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tickEn = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         extEnable = 1'b0;
  logic         intAck = 1'b0;
  logic         excReq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [W-1:0] expCount;
  logic         expPend;

  always #10 clk = ~clk;  // 50 MHz

  dec_timer u_dec_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .extEnable(extEnable), .intAck(intAck), .excReq(excReq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements
  function automatic logic [W:0] modelNext(input logic [W-1:0] c, input logic p,
      input bit tk, input bit wr, input logic [W-1:0] d, input bit ak);
    logic [W-1:0] nc;
    logic np;
    bit wrap;
    wrap = tk && !wr && (c == '0);
    if (wr)      nc = d;
    else if (tk) nc = c - 1;
    else         nc = c;
    if (wrap)                  np = 1'b1;
    else if (ak || (wr && !d[W-1])) np = 1'b0;
    else                       np = p;
    return {np, nc};
  endfunction

  // One cycle: drive at negedge, apply edge, compare at next negedge
  task automatic cyc(input bit tk, input bit wr, input logic [W-1:0] d,
                     input bit ak, input bit en, input string req);
    logic [W:0] nx;
    tickEn = tk; wrEn = wr; wrData = d; intAck = ak; extEnable = en;
    nx = modelNext(expCount, expPend, tk, wr, d, ak);
    @(posedge clk);
    expCount = nx[W-1:0];
    expPend  = nx[W];
    @(negedge clk);
    check(rdData == expCount, req, "rdData", rdData, expCount);
    check(excReq == (expPend && en), req, "excReq", W'(excReq), W'(expPend && en));
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "WATCHDOG", "timeout", '0, '0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    expCount = '1;
    expPend  = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    extEnable = 1'b1;
    #1;
    // R1 reset state
    check(rdData == 32'hFFFF_FFFF, "R1", "rdData", rdData, 32'hFFFF_FFFF);
    check(excReq == 1'b0, "R1", "excReq", W'(excReq), '0);
    @(negedge clk);

    cyc(0, 1, 32'd2, 0, 1, "R2");          // load 2
    cyc(1, 0, '0, 0, 1, "R3");             // 1
    cyc(1, 0, '0, 0, 1, "R5");             // reaching 0: no request
    check(excReq == 1'b0, "R5", "at zero", W'(excReq), '0);
    cyc(1, 0, '0, 0, 0, "R5");             // wrap while masked
    check(rdData == 32'hFFFF_FFFF, "R5", "wrap value", rdData, 32'hFFFF_FFFF);
    repeat (5) cyc(0, 0, '0, 0, 0, "R6");  // held, masked
    cyc(0, 0, '0, 0, 1, "R6");             // unmask
    check(excReq == 1'b1, "R6", "unmasked", W'(excReq), 1);
    cyc(0, 0, '0, 1, 1, "R7");             // ack clears
    check(excReq == 1'b0, "R7", "after ack", W'(excReq), '0);
    cyc(0, 1, 32'h8000_0000, 0, 1, "R2");
    cyc(1, 0, '0, 0, 1, "R5");             // 0x7FFFFFFF, no request
    check(excReq == 1'b0, "R5", "top-bit fall", W'(excReq), '0);
    cyc(0, 1, '0, 0, 1, "R2");
    cyc(1, 0, '0, 1, 1, "R7");             // wrap with ack: wrap wins
    check(excReq == 1'b1, "R7", "wrap beats ack", W'(excReq), 1);
    cyc(0, 1, 32'h9000_0000, 0, 1, "R8");  // top bit 1 keeps pending
    check(excReq == 1'b1, "R8", "msb1 write", W'(excReq), 1);
    cyc(0, 1, 32'd5, 0, 1, "R8");          // top bit 0 clears
    check(excReq == 1'b0, "R8", "msb0 write", W'(excReq), '0);
    cyc(1, 1, '0, 0, 1, "R4");             // write wins over tick
    check(rdData == '0, "R4", "write+tick", rdData, '0);
    cyc(1, 1, '0, 0, 1, "R4");             // again at zero: still no wrap
    check(excReq == 1'b0, "R4", "no wrap", W'(excReq), '0);
    cyc(0, 1, 32'hFFFF_FFFF, 0, 1, "R9");  // write sets top bit: no request
    check(excReq == 1'b0, "R9", "write no set", W'(excReq), '0);

    for (int i = 0; i < 4000; i++) begin
      bit tk, wr, ak, en;
      logic [W-1:0] d;
      int sel;
      tk = ($urandom % 4) != 0;
      wr = ($urandom % 12) == 0;
      ak = ($urandom % 16) == 0;
      en = ($urandom % 3) != 0;
      sel = $urandom % 3;
      if (sel == 0)      d = W'($urandom % 6);
      else if (sel == 1) d = 32'h8000_0000 + W'($urandom % 4);
      else               d = W'($urandom);
      cyc(tk, wr, d, ak, en, "R3/R5 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule